// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It holds two component predictors and a chooser. The local component keeps a short outcome history for each branch and uses that pattern to pick a 2-bit counter. This lets it learn repeating sequences such as three not-taken outcomes followed by one taken. The global component keeps one shift register of recent outcomes from all branches. It XORs that register with the branch address to pick a counter from a second table. A 2-bit chooser per branch selects which component's answer is given. The chooser moves toward whichever component was right when the two disagree.

The fetch stage presents a PC and reads the prediction back in the same cycle. This read is combinational from the table state. The two component predictions are also exposed, so the pipeline can carry them with the branch. When the branch resolves, the pipeline presents the PC, the real outcome and the two carried component predictions on the update port. All tables and the global history then change at the next clock edge. There are no tags: branches whose index bits are equal share entries.

Top module: `tournament_bp`

## Requirements
- R1: After reset, every direction counter holds 1 (weakly not-taken), every local history and the global history hold all zeros, and every chooser holds 0. As a result, every PC predicts not-taken on all three prediction outputs.
- R2: Direction counters are 2-bit unsigned and saturating. A counter predicts taken when its value is 2 or 3. An update moves it one step toward the outcome (taken toward 3, not-taken toward 0), and it holds at 0 and at 3.
- R3: Each branch has a local history of LHIST_W bits (5 by default), selected by PC bits [ALIGN_W+LIDX_W-1:ALIGN_W]. On update, the history shifts left and the outcome enters at bit 0 (1 = taken). The history value alone selects the local direction counter.
- R4: The global history is a GHIST_W-bit shift register. Every update shifts it left and puts the outcome in bit 0. The global counter index is PC bits [ALIGN_W+GHIST_W-1:ALIGN_W] XOR the global history.
- R5: The chooser of a branch is a 2-bit two's-complement value in the range -2..1, selected by the same PC bits as the local history. On update, it adds 1 when the supplied global prediction matched the outcome and the local one did not. It subtracts 1 in the opposite case and is left unchanged otherwise. It saturates at 1 and at -2.
- R6: pred_taken equals pred_global when the chooser of pred_pc is non-negative, and equals pred_local otherwise.
- R7: From a chooser value of 1, a single update in which only the local prediction was right leaves the selection on the global component.
- R8: When pred_pc and upd_pc name the same entries in one cycle, the prediction reflects the table state from before that update.
- R9: pred_local and pred_global report the component predictions for pred_pc: bit 1 of the selected local and global counters respectively.
- R10: While upd_valid is low, no table and no history changes, so the predictions for a held pred_pc stay constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pred_pc | input | PC_W | Fetch PC to predict |
| pred_taken | output | 1 | Final prediction, 1 = taken |
| pred_local | output | 1 | Local component prediction for pred_pc |
| pred_global | output | 1 | Global component prediction for pred_pc |
| upd_valid | input | 1 | Apply an update at the next edge |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Real outcome, 1 = taken |
| upd_local_pred | input | 1 | Local prediction carried with the branch |
| upd_global_pred | input | 1 | Global prediction carried with the branch |

## Verification
A prediction and an update can fall in the same cycle and reach the same local history, counter and chooser entries. The bench provokes this by presenting the same PC on both ports, and by sharing index bits across a pseudo-random sweep. In each such case, the outputs sampled before the edge must match a bench model that has not yet applied the update. After the edge, the next prediction must match the updated model.

// File: rtl/tp_pkg.sv
package tp_pkg;

  localparam logic [1:0] CTR_RESET    = 2'b01; // weakly not-taken
  localparam logic [1:0] CHOOSE_RESET = 2'b00; // weakly global
  localparam logic [1:0] CHOOSE_MAX   = 2'b01; // +1
  localparam logic [1:0] CHOOSE_MIN   = 2'b10; // -2

  function automatic logic [1:0] ctr_step(input logic [1:0] c, input logic taken);
    logic [1:0] r;
    if (taken) r = (c == 2'b11) ? c : c + 2'b01;
    else       r = (c == 2'b00) ? c : c - 2'b01;
    return r;
  endfunction

  function automatic logic [1:0] choose_step(input logic [1:0] c,
                                             input logic glob_ok,
                                             input logic loc_ok);
    logic [1:0] r;
    r = c;
    if (glob_ok && !loc_ok && c != CHOOSE_MAX) r = c + 2'b01;
    else if (loc_ok && !glob_ok && c != CHOOSE_MIN) r = c - 2'b01;
    return r;
  endfunction

endpackage

// File: rtl/tp_table.sv
module tp_table #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 2,
  parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rd_addr_a,
  output logic [DATA_W-1:0] rd_data_a,
  input  logic [ADDR_W-1:0] rd_addr_b,
  output logic [DATA_W-1:0] rd_data_b,
  input  logic              we,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // asynchronous read ports: old contents until the edge
  assign rd_data_a = mem[rd_addr_a];
  assign rd_data_b = mem[rd_addr_b];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= RESET_VAL;
    end else if (we) begin
      mem[wr_addr] <= wr_data;
    end
  end
endmodule

// File: rtl/tp_ghist.sv
module tp_ghist #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] hist
);
  always_ff @(posedge clk) begin
    if (rst)           hist <= '0;
    else if (shift_en) hist <= {hist[W-2:0], bit_in};
  end
endmodule

// File: rtl/tournament_bp.sv
module tournament_bp
  import tp_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int ALIGN_W = 2,
  parameter int LIDX_W  = 6,
  parameter int LHIST_W = 5,
  parameter int GHIST_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] pred_pc,
  output logic            pred_taken,
  output logic            pred_local,
  output logic            pred_global,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic            upd_local_pred,
  input  logic            upd_global_pred
);
  localparam int IDX_TOP = ALIGN_W + ((LIDX_W > GHIST_W) ? LIDX_W : GHIST_W);

  initial begin
    if (IDX_TOP > PC_W) $error("tournament_bp: index bits exceed PC width");
    if (LHIST_W < 2 || GHIST_W < 2) $error("tournament_bp: histories need 2+ bits");
  end

  // index selection
  logic [LIDX_W-1:0]  p_lidx, u_lidx;
  logic [GHIST_W-1:0] p_gidx, u_gidx, ghist;

  assign p_lidx = pred_pc[ALIGN_W +: LIDX_W];
  assign u_lidx = upd_pc[ALIGN_W +: LIDX_W];
  assign p_gidx = pred_pc[ALIGN_W +: GHIST_W] ^ ghist;
  assign u_gidx = upd_pc[ALIGN_W +: GHIST_W] ^ ghist;

  // local histories
  logic [LHIST_W-1:0] p_lhist, u_lhist, lh_wdata;
  assign lh_wdata = {u_lhist[LHIST_W-2:0], upd_taken};

  tp_table #(.ADDR_W(LIDX_W), .DATA_W(LHIST_W), .RESET_VAL('0)) u_lhist_tab (
    .clk(clk), .rst(rst),
    .rd_addr_a(p_lidx), .rd_data_a(p_lhist),
    .rd_addr_b(u_lidx), .rd_data_b(u_lhist),
    .we(upd_valid), .wr_addr(u_lidx), .wr_data(lh_wdata)
  );

  // local pattern counters
  logic [1:0] p_lctr, u_lctr, l_wdata;
  assign l_wdata = ctr_step(u_lctr, upd_taken);

  tp_table #(.ADDR_W(LHIST_W), .DATA_W(2), .RESET_VAL(CTR_RESET)) u_lpat_tab (
    .clk(clk), .rst(rst),
    .rd_addr_a(p_lhist), .rd_data_a(p_lctr),
    .rd_addr_b(u_lhist), .rd_data_b(u_lctr),
    .we(upd_valid), .wr_addr(u_lhist), .wr_data(l_wdata)
  );

  // global counters
  logic [1:0] p_gctr, u_gctr, g_wdata;
  assign g_wdata = ctr_step(u_gctr, upd_taken);

  tp_table #(.ADDR_W(GHIST_W), .DATA_W(2), .RESET_VAL(CTR_RESET)) u_gpat_tab (
    .clk(clk), .rst(rst),
    .rd_addr_a(p_gidx), .rd_data_a(p_gctr),
    .rd_addr_b(u_gidx), .rd_data_b(u_gctr),
    .we(upd_valid), .wr_addr(u_gidx), .wr_data(g_wdata)
  );

  // choosers
  logic [1:0] p_ch, u_ch, ch_wdata;
  assign ch_wdata = choose_step(u_ch, upd_global_pred == upd_taken,
                                upd_local_pred == upd_taken);

  tp_table #(.ADDR_W(LIDX_W), .DATA_W(2), .RESET_VAL(CHOOSE_RESET)) u_choose_tab (
    .clk(clk), .rst(rst),
    .rd_addr_a(p_lidx), .rd_data_a(p_ch),
    .rd_addr_b(u_lidx), .rd_data_b(u_ch),
    .we(upd_valid), .wr_addr(u_lidx), .wr_data(ch_wdata)
  );

  // global history
  tp_ghist #(.W(GHIST_W)) u_ghist (
    .clk(clk), .rst(rst), .shift_en(upd_valid), .bit_in(upd_taken), .hist(ghist)
  );

  // prediction: chooser sign bit clear selects the global component
  assign pred_local  = p_lctr[1];
  assign pred_global = p_gctr[1];
  assign pred_taken  = p_ch[1] ? pred_local : pred_global;

endmodule

// File: rtl/tp_checker.sv
module tp_checker #(
  parameter int PC_W    = 32,
  parameter int GHIST_W = 8
) (
  input logic               clk,
  input logic               rst,
  input logic [PC_W-1:0]    pred_pc,
  input logic               pred_taken,
  input logic               pred_local,
  input logic               pred_global,
  input logic               upd_valid,
  input logic               upd_taken,
  input logic [GHIST_W-1:0] ghist,
  input logic [1:0]         u_gctr,
  input logic [1:0]         g_wdata,
  input logic [1:0]         u_ch,
  input logic [1:0]         ch_wdata
);
  // R4: global history shifts in each resolved outcome
  a_r4_ghist_shift: assert property (@(posedge clk) disable iff (rst)
    upd_valid |=> ghist == {$past(ghist[GHIST_W-2:0]), $past(upd_taken)});

  // R2: a counter write moves at most one step
  a_r2_one_step: assert property (@(posedge clk) disable iff (rst)
    upd_valid |-> (g_wdata == u_gctr) || (g_wdata == u_gctr + 2'b01) ||
                  (g_wdata == u_gctr - 2'b01));

  // R2: no wrap past the ends
  a_r2_no_wrap: assert property (@(posedge clk) disable iff (rst)
    upd_valid |-> !((u_gctr == 2'b11 && g_wdata == 2'b00) ||
                    (u_gctr == 2'b00 && g_wdata == 2'b11)));

  // R5: chooser never wraps from +1 to -2 or back
  a_r5_chooser_no_wrap: assert property (@(posedge clk) disable iff (rst)
    upd_valid |-> !((u_ch == 2'b01 && ch_wdata == 2'b10) ||
                    (u_ch == 2'b10 && ch_wdata == 2'b01)));

  // R6: agreeing components fix the final prediction
  a_r6_agree: assert property (@(posedge clk) disable iff (rst)
    (pred_local == pred_global) |-> pred_taken == pred_local);

  // R10: no update means held predictions for a held PC
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
    ($past(!upd_valid) && $stable(pred_pc)) |->
      ($stable(pred_taken) && $stable(pred_local) && $stable(pred_global) && $stable(ghist)));
endmodule

bind tournament_bp tp_checker #(.PC_W(PC_W), .GHIST_W(GHIST_W)) u_tp_checker (
  .clk(clk), .rst(rst), .pred_pc(pred_pc), .pred_taken(pred_taken),
  .pred_local(pred_local), .pred_global(pred_global), .upd_valid(upd_valid),
  .upd_taken(upd_taken), .ghist(ghist), .u_gctr(u_gctr), .g_wdata(g_wdata),
  .u_ch(u_ch), .ch_wdata(ch_wdata)
);

// File: tb/tournament_bp_test.sv
module tournament_bp_test;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 16, ALIGN_W = 2, LIDX_W = 3, LHIST_W = 5, GHIST_W = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic [PC_W-1:0] pred_pc = '0, upd_pc = '0;
  logic upd_valid = 1'b0, upd_taken = 1'b0, upd_local_pred = 1'b0, upd_global_pred = 1'b0;
  logic pred_taken, pred_local, pred_global;

  always #(CLK_PERIOD/2) clk = ~clk;

  tournament_bp #(.PC_W(PC_W), .ALIGN_W(ALIGN_W), .LIDX_W(LIDX_W),
                  .LHIST_W(LHIST_W), .GHIST_W(GHIST_W)) uut (
    .clk(clk), .rst(rst), .pred_pc(pred_pc), .pred_taken(pred_taken),
    .pred_local(pred_local), .pred_global(pred_global), .upd_valid(upd_valid),
    .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_local_pred(upd_local_pred),
    .upd_global_pred(upd_global_pred)
  );

  int checks = 0, errors = 0;

  // bench model of the requirements
  logic [LHIST_W-1:0] m_lh [1<<LIDX_W];
  int                 m_lp [1<<LHIST_W];
  int                 m_gp [1<<GHIST_W];
  int                 m_ch [1<<LIDX_W];
  logic [GHIST_W-1:0] m_gh;

  task automatic model_reset();
    for (int i = 0; i < (1<<LIDX_W); i++) begin m_lh[i] = '0; m_ch[i] = 0; end
    for (int i = 0; i < (1<<LHIST_W); i++) m_lp[i] = 1;
    for (int i = 0; i < (1<<GHIST_W); i++) m_gp[i] = 1;
    m_gh = '0;
  endtask

  function automatic int li(input logic [PC_W-1:0] pc);
    return int'(pc[ALIGN_W +: LIDX_W]);
  endfunction
  function automatic int gi(input logic [PC_W-1:0] pc);
    return int'(pc[ALIGN_W +: GHIST_W] ^ m_gh);
  endfunction
  function automatic logic m_local(input logic [PC_W-1:0] pc);
    return m_lp[m_lh[li(pc)]] >= 2;
  endfunction
  function automatic logic m_global(input logic [PC_W-1:0] pc);
    return m_gp[gi(pc)] >= 2;
  endfunction
  function automatic logic m_final(input logic [PC_W-1:0] pc);
    return (m_ch[li(pc)] >= 0) ? m_global(pc) : m_local(pc);
  endfunction
  function automatic int stepc(input int c, input logic t);
    return t ? ((c < 3) ? c + 1 : 3) : ((c > 0) ? c - 1 : 0);
  endfunction

  task automatic model_update(input logic [PC_W-1:0] pc, input logic t,
                              input logic lp, input logic gp);
    int l, g;
    l = li(pc); g = gi(pc);
    m_lp[m_lh[l]] = stepc(m_lp[m_lh[l]], t);
    m_gp[g] = stepc(m_gp[g], t);
    if (gp == t && lp != t && m_ch[l] < 1) m_ch[l] = m_ch[l] + 1;
    else if (lp == t && gp != t && m_ch[l] > -2) m_ch[l] = m_ch[l] - 1;
    m_lh[l] = {m_lh[l][LHIST_W-2:0], t};
    m_gh = {m_gh[GHIST_W-2:0], t};
  endtask

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // one cycle: drive, check before the edge against pre-update model, then apply
  task automatic cycle(input logic [PC_W-1:0] ppc, input logic uv,
                       input logic [PC_W-1:0] upc, input logic ut,
                       input logic ulp, input logic ugp, input string tag);
    @(negedge clk);
    pred_pc = ppc; upd_valid = uv; upd_pc = upc; upd_taken = ut;
    upd_local_pred = ulp; upd_global_pred = ugp;
    #1;
    chk(pred_local,  m_local(ppc),  {tag, " R9 local"});
    chk(pred_global, m_global(ppc), {tag, " R9 global"});
    chk(pred_taken,  m_final(ppc),  {tag, " R6 final"});
    @(posedge clk);
    if (uv) model_update(upc, ut, ulp, ugp);
  endtask

  logic [15:0] lfsr = 16'hACE1;
  function automatic logic [15:0] nxt(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [PC_W-1:0] pc;
    logic lp, gp, t;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1: reset state, every PC not-taken
    for (int i = 0; i < 64; i++) begin
      @(negedge clk); pred_pc = PC_W'(i * 4); #1;
      chk(pred_taken, 1'b0, "R1 reset final");
      chk(pred_local, 1'b0, "R1 reset local");
      chk(pred_global, 1'b0, "R1 reset global");
    end

    // R3: periodic N N N T pattern on one branch, same-cycle predict+update (R8)
    pc = 16'h0010;
    for (int k = 0; k < 48; k++) begin
      t = (k % 4) == 3;
      lp = m_local(pc); gp = m_global(pc);
      if (k >= 40) begin
        @(negedge clk); pred_pc = pc; upd_valid = 1'b0; #1;
        chk(pred_local, t, "R3 learned pattern");
      end
      cycle(pc, 1'b1, pc, t, lp, gp, "R3 R8 pattern");
    end

    // R2: saturation on a fresh branch, held outcome taken then not-taken
    pc = 16'h0004;
    for (int k = 0; k < 12; k++)
      cycle(pc, 1'b1, pc, k < 6, m_local(pc), m_global(pc), "R2 saturate");

    // R5 R7: chooser driven to +1, then one local-only win
    pc = 16'h0008;
    cycle(pc, 1'b1, pc, 1'b1, 1'b0, 1'b1, "R5 up");
    cycle(pc, 1'b1, pc, 1'b1, 1'b0, 1'b1, "R5 up sat");
    cycle(pc, 1'b1, pc, 1'b1, 1'b1, 1'b1, "R5 agree");
    cycle(pc, 1'b1, pc, 1'b1, 1'b1, 1'b0, "R7 one miss");
    @(negedge clk); pred_pc = pc; upd_valid = 1'b0; #1;
    chk(pred_taken, pred_global, "R7 still global");
    for (int k = 0; k < 4; k++)
      cycle(pc, 1'b1, pc, 1'b0, 1'b0, 1'b1, "R5 down");

    // R10: updates withheld, predictions held
    for (int k = 0; k < 8; k++)
      cycle(16'h0010, 1'b0, 16'h0010, 1'b1, 1'b0, 1'b1, "R10 idle");

    // R4 R8: pseudo-random sweep, shared indices, mixed valid and flipped preds
    for (int k = 0; k < 3000; k++) begin
      logic [PC_W-1:0] ppc, upc2;
      lfsr = nxt(lfsr);
      upc2 = {10'd0, lfsr[5:0]};
      ppc  = lfsr[6] ? upc2 : {10'd0, lfsr[12:7]};
      lp = m_local(upc2) ^ lfsr[13];
      gp = m_global(upc2) ^ lfsr[14];
      t  = lfsr[15] ^ upc2[3];
      cycle(ppc, lfsr[2] | lfsr[9], upc2, t, lp, gp, "R4 R8 sweep");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule